// File: doc/BRIEF.md
# Tuner Output Formatter

This block sits at the end of a digital down-conversion chain. It takes decimated complex samples, each marked by a one-cycle input strobe, and turns them into the final output stream. Each sample first passes through a fine gain: a 16-bit mantissa, where 256 means unity, times a coarse power-of-two shift. Two optional sign manipulations can follow. Negating the Q component mirrors the spectrum about zero frequency. Negating both components on every other sample moves the spectrum by half the output sample rate.

The block then delivers the result in one of two formats. In complex format it emits one I/Q pair per input sample. In real format it mixes the stream by a quarter of the real output rate and emits two real words per input sample on consecutive cycles, which doubles the output rate. Each word is reduced to 10, 12, 14 or 16 bits with rounding that is symmetric about zero, and saturates instead of wrapping. A readback pair holds the two words derived from the latest sample, so that a host can monitor output power.

Top module: `tuner_out_fmt`

## Requirements
- R1: After reset, out_valid, out_real, out_i, out_q, rb_i and rb_q are all zero.
- R2: In complex format (cfg_real=0), an input strobe in cycle n produces out_valid=1 and out_real=0 in cycle n+1, with out_i and out_q derived from in_i and in_q of cycle n.
- R3: Each component is scaled by x*cfg_mant*2^cfg_shift/256 (cfg_mant unsigned, 256 is unity, cfg_shift from 0 to 7) before the word-size reduction.
- R4: The reduction drops low bits with rounding to the nearest value, and exact halves go away from zero (+1.5 becomes 2, -1.5 becomes -2).
- R5: A rounded value above the largest code of the selected width gives that largest code, and a value below the smallest code gives the smallest code.
- R6: cfg_wsel selects the output width: 0 gives 10 bits, 1 gives 12, 2 gives 14 and 3 gives 16. A W-bit result is the scaled value divided by 2^(16-W), and it appears sign-extended on the 16-bit output.
- R7: With cfg_inv=1, the Q component is negated before rounding. I is not affected.
- R8: Accepted samples are counted from 0 after reset, in both formats and whatever cfg_half is set to. With cfg_half=1, both components of odd-numbered samples are negated before rounding.
- R9: In real format (cfg_real=1), each input strobe gives two outputs with out_real=1 and out_q=0: one in the next cycle and one in the cycle after it. Over successive real-format samples the values follow the rotation I, -Q, -I, Q. The rotation restarts at I after any complex-format sample.
- R10: rb_i and rb_q both take the I-path and Q-path words of a sample in the cycle of its first output, and hold otherwise. In complex format they equal out_i and out_q.
- R11: out_valid is low in any cycle that is neither the cycle after an input strobe nor the second real-format output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | In-phase input, two's complement |
| in_q | input | 16 | Quadrature input, two's complement |
| cfg_mant | input | 16 | Gain mantissa, unsigned, 256 means unity |
| cfg_shift | input | 3 | Coarse gain, left shift of 0 to 7 |
| cfg_inv | input | 1 | Spectral inversion enable |
| cfg_half | input | 1 | Half-rate spectrum offset enable |
| cfg_real | input | 1 | Real output format select |
| cfg_wsel | input | 2 | Output width select |
| out_valid | output | 1 | Output strobe |
| out_real | output | 1 | High when the output is a real word |
| out_i | output | 16 | I word, or the real word in real format |
| out_q | output | 16 | Q word, zero in real format |
| rb_i | output | 16 | Readback of the latest I-path word |
| rb_q | output | 16 | Readback of the latest Q-path word |

## Verification
Three sign sources act on the Q path in the same cycle: the inversion, the odd-sample negation and the real-format rotation. Each of them can also meet saturation when the input is full-scale negative, because negating -32768 gives +32768, which only saturation can bring back into range. The bench turns on inversion and the half-rate offset together, drives Q at -32768 in both formats, and compares each word with a model that multiplies the signs together and then rounds and saturates by plain arithmetic. The width and gain sweeps are judged by the same model.

// File: rtl/tof_pkg.sv
package tof_pkg;
    localparam int NUM_WIDTHS = 4;   // selectable output widths
    localparam int WIDTH_STEP = 2;   // bits between adjacent widths
    typedef logic [1:0] wsel_t;
endpackage

// File: rtl/tof_gain.sv
// Fine gain times coarse shift, with an optional exact negation.
module tof_gain #(
    parameter int IN_W   = 16,
    parameter int MANT_W = 16,
    parameter int SH_W   = 3,
    parameter int P_W    = IN_W + MANT_W + (1 << SH_W) + 1
) (
    input  logic signed [IN_W-1:0] x,
    input  logic [MANT_W-1:0]      mant,
    input  logic [SH_W-1:0]        sh,
    input  logic                   neg,
    output logic signed [P_W-1:0]  p
);
    logic signed [IN_W+MANT_W:0] prod;
    logic signed [P_W-1:0]       wide;

    always_comb begin
        prod = x * $signed({1'b0, mant});
        wide = P_W'(prod) <<< sh;
        p    = neg ? -wide : wide;
    end
endmodule

// File: rtl/tof_round_sat.sv
// Symmetric rounding to one of four widths, then saturation.
module tof_round_sat
    import tof_pkg::*;
#(
    parameter int P_W       = 41,
    parameter int OUT_W     = 16,
    parameter int BASE_DROP = 8
) (
    input  logic signed [P_W-1:0]  p,
    input  wsel_t                  wsel,
    output logic signed [OUT_W-1:0] y
);
    logic signed [OUT_W-1:0] cand [NUM_WIDTHS];

    for (genvar k = 0; k < NUM_WIDTHS; k++) begin : g_w
        localparam int W = OUT_W - WIDTH_STEP * (NUM_WIDTHS - 1 - k);
        localparam int D = BASE_DROP + WIDTH_STEP * (NUM_WIDTHS - 1 - k);
        localparam logic signed [P_W-1:0] HALF = P_W'(64'sd1 <<< (D - 1));
        localparam logic signed [P_W-1:0] MAXV = P_W'((64'sd1 <<< (W - 1)) - 64'sd1);
        localparam logic signed [P_W-1:0] MINV = -MAXV - P_W'(1);

        logic signed [P_W-1:0] adj, biased, shifted;

        always_comb begin
            adj     = p[P_W-1] ? HALF - P_W'(1) : HALF;
            biased  = p + adj;
            shifted = biased >>> D;
            if (shifted > MAXV)      cand[k] = OUT_W'(MAXV);
            else if (shifted < MINV) cand[k] = OUT_W'(MINV);
            else                     cand[k] = OUT_W'(shifted);
        end
    end

    assign y = cand[wsel];
endmodule

// File: rtl/tuner_out_fmt.sv
module tuner_out_fmt
    import tof_pkg::*;
#(
    parameter int IN_W      = 16,
    parameter int MANT_W    = 16,
    parameter int MANT_FRAC = 8,
    parameter int SH_W      = 3,
    parameter int OUT_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_i,
    input  logic [IN_W-1:0]   in_q,
    input  logic [MANT_W-1:0] cfg_mant,
    input  logic [SH_W-1:0]   cfg_shift,
    input  logic              cfg_inv,
    input  logic              cfg_half,
    input  logic              cfg_real,
    input  logic [1:0]        cfg_wsel,
    output logic              out_valid,
    output logic              out_real,
    output logic [OUT_W-1:0]  out_i,
    output logic [OUT_W-1:0]  out_q,
    output logic [OUT_W-1:0]  rb_i,
    output logic [OUT_W-1:0]  rb_q
);
    localparam int P_W       = IN_W + MANT_W + (1 << SH_W) + 1;
    localparam int BASE_DROP = MANT_FRAC + IN_W - OUT_W;

    typedef struct packed {
        logic                    vld;
        logic                    rl;
        logic signed [OUT_W-1:0] oi;
        logic signed [OUT_W-1:0] oq;
        logic                    pend;   // second real word waiting
        logic signed [OUT_W-1:0] pval;
        logic                    half;   // sample parity since reset
        logic                    rot;    // real rotation parity
        logic signed [OUT_W-1:0] rbi;
        logic signed [OUT_W-1:0] rbq;
    } st_t;

    st_t s_d, s_q;

    logic                    neg_base;
    logic                    neg_a [2];
    logic signed [IN_W-1:0]  x_a   [2];
    logic signed [P_W-1:0]   p_a   [2];
    logic signed [OUT_W-1:0] y_a   [2];

    // Every sign source is folded into the product before rounding.
    always_comb begin
        neg_base = cfg_half & s_q.half;
        neg_a[0] = neg_base ^ (cfg_real & s_q.rot);
        neg_a[1] = neg_base ^ cfg_inv ^ (cfg_real & ~s_q.rot);
        x_a[0]   = $signed(in_i);
        x_a[1]   = $signed(in_q);
    end

    for (genvar g = 0; g < 2; g++) begin : g_path
        tof_gain #(
            .IN_W(IN_W), .MANT_W(MANT_W), .SH_W(SH_W), .P_W(P_W)
        ) u_gain (
            .x(x_a[g]), .mant(cfg_mant), .sh(cfg_shift), .neg(neg_a[g]), .p(p_a[g])
        );
        tof_round_sat #(
            .P_W(P_W), .OUT_W(OUT_W), .BASE_DROP(BASE_DROP)
        ) u_rs (
            .p(p_a[g]), .wsel(cfg_wsel), .y(y_a[g])
        );
    end

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        if (in_valid) begin
            s_d.vld  = 1'b1;
            s_d.rl   = cfg_real;
            s_d.oi   = y_a[0];
            s_d.oq   = cfg_real ? '0 : y_a[1];
            s_d.pend = cfg_real;
            s_d.pval = y_a[1];
            s_d.rbi  = y_a[0];
            s_d.rbq  = y_a[1];
            s_d.half = ~s_q.half;
            s_d.rot  = cfg_real & ~s_q.rot;
        end else if (s_q.pend) begin
            s_d.vld  = 1'b1;
            s_d.rl   = 1'b1;
            s_d.oi   = s_q.pval;
            s_d.oq   = '0;
            s_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.vld;
    assign out_real  = s_q.rl;
    assign out_i     = s_q.oi;
    assign out_q     = s_q.oq;
    assign rb_i      = s_q.rbi;
    assign rb_q      = s_q.rbq;
endmodule

// File: rtl/tuner_out_fmt_chk.sv
module tuner_out_fmt_chk #(
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             cfg_real,
    input logic [1:0]       cfg_wsel,
    input logic             out_valid,
    input logic             out_real,
    input logic [OUT_W-1:0] out_i,
    input logic [OUT_W-1:0] out_q,
    input logic [OUT_W-1:0] rb_i,
    input logic [OUT_W-1:0] rb_q
);
    localparam int LIM10 = 1 << (OUT_W - 7);

    assert_real_q_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_real) |-> (out_q == '0));

    assert_real_two_words_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_real) |=> ##1 (out_valid && out_real));

    assert_cplx_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_real) |-> $past(in_valid));

    assert_rb_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(rb_i) && $stable(rb_q)));

    assert_rb_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_real) |-> (rb_i == out_i && rb_q == out_q));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_real && $past(cfg_wsel) == 2'd0) |->
        ($signed(out_i) < LIM10 && $signed(out_i) >= -LIM10 &&
         $signed(out_q) < LIM10 && $signed(out_q) >= -LIM10));

    assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !(in_valid == 1'b0 && out_valid && out_real && $past(in_valid) == 1'b0) && !(out_real && !$past(in_valid)))
        |=> (out_valid -> out_real));
endmodule

bind tuner_out_fmt tuner_out_fmt_chk #(.OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cfg_real(cfg_real),
    .cfg_wsel(cfg_wsel), .out_valid(out_valid), .out_real(out_real),
    .out_i(out_i), .out_q(out_q), .rb_i(rb_i), .rb_q(rb_q)
);

// File: tb/tb_tuner_out_fmt.sv
module tb_tuner_out_fmt;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_i = '0, in_q = '0;
    logic [15:0] cfg_mant = 16'd256;
    logic [2:0]  cfg_shift = '0;
    logic        cfg_inv = 1'b0, cfg_half = 1'b0, cfg_real = 1'b0;
    logic [1:0]  cfg_wsel = 2'd3;
    logic        out_valid, out_real;
    logic [15:0] out_i, out_q, rb_i, rb_q;

    int n_checks = 0;
    int n_fail = 0;
    bit half_ph = 1'b0;   // model of sample parity
    bit rot_ph  = 1'b0;   // model of real rotation parity

    always #(CLK_PERIOD/2) clk = ~clk;

    tuner_out_fmt dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .cfg_mant(cfg_mant), .cfg_shift(cfg_shift), .cfg_inv(cfg_inv),
        .cfg_half(cfg_half), .cfg_real(cfg_real), .cfg_wsel(cfg_wsel),
        .out_valid(out_valid), .out_real(out_real), .out_i(out_i), .out_q(out_q),
        .rb_i(rb_i), .rb_q(rb_q)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Scale, sign, round half away from zero, saturate, sign-extend.
    function automatic logic [15:0] model(input int x, input int mant, input int sh,
                                          input bit neg, input int ws);
        longint p, mag, r, mx;
        int w, d;
        p = longint'(x) * longint'(mant);
        p = p * (longint'(1) << sh);
        if (neg) p = -p;
        w = 10 + 2 * ws;
        d = 24 - w;
        mag = (p < 0) ? -p : p;
        r = (mag + (longint'(1) << (d - 1))) / (longint'(1) << d);
        if (p < 0) r = -r;
        mx = (longint'(1) << (w - 1)) - 1;
        if (r > mx) r = mx;
        if (r < -mx - 1) r = -mx - 1;
        return r[15:0];
    endfunction

    function automatic longint sx(input logic [15:0] v);
        return longint'($signed(v));
    endfunction

    task automatic send_cplx(input int xi, input int xq, input string req);
        logic [15:0] ei, eq;
        bit nb;
        nb = cfg_half & half_ph;
        ei = model(xi, int'(cfg_mant), int'(cfg_shift), nb, int'(cfg_wsel));
        eq = model(xq, int'(cfg_mant), int'(cfg_shift), nb ^ cfg_inv, int'(cfg_wsel));
        in_i = 16'(xi); in_q = 16'(xq); cfg_real = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1 && out_real == 1'b0, {req, " R2 strobe"}, longint'(out_valid), 1);
        chk(out_i == ei, {req, " I"}, sx(out_i), sx(ei));
        chk(out_q == eq, {req, " Q"}, sx(out_q), sx(eq));
        chk(rb_i == ei && rb_q == eq, {req, " R10 readback"}, sx(rb_q), sx(eq));
        half_ph = ~half_ph;
        rot_ph  = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R11 idle after complex", longint'(out_valid), 0);
    endtask

    task automatic send_real(input int xi, input int xq, input string req);
        logic [15:0] e1, e2;
        bit nb;
        nb = cfg_half & half_ph;
        e1 = model(xi, int'(cfg_mant), int'(cfg_shift), nb ^ rot_ph, int'(cfg_wsel));
        e2 = model(xq, int'(cfg_mant), int'(cfg_shift), nb ^ cfg_inv ^ ~rot_ph, int'(cfg_wsel));
        in_i = 16'(xi); in_q = 16'(xq); cfg_real = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid && out_real && out_q == 16'd0, {req, " R9 first word flags"}, longint'(out_real), 1);
        chk(out_i == e1, {req, " R9 first word"}, sx(out_i), sx(e1));
        chk(rb_i == e1 && rb_q == e2, {req, " R10 readback real"}, sx(rb_q), sx(e2));
        @(negedge clk);
        chk(out_valid && out_real && out_q == 16'd0, {req, " R9 second word flags"}, longint'(out_valid), 1);
        chk(out_i == e2, {req, " R9 second word"}, sx(out_i), sx(e2));
        half_ph = ~half_ph;
        rot_ph  = ~rot_ph;
        @(negedge clk);
        chk(out_valid == 1'b0, "R11 idle after real", longint'(out_valid), 0);
        cfg_real = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int vals[8] = '{0, 1, -1, 3, -3, 32767, -32768, 12345};
        int mants[5] = '{0, 128, 256, 300, 65535};
        int shs[4] = '{0, 1, 3, 7};

        repeat (3) @(negedge clk);
        chk(out_valid == 0 && out_real == 0 && out_i == 0 && out_q == 0 && rb_i == 0 && rb_q == 0,
            "R1 reset state", longint'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 ties at 16 bits with gain one half
        cfg_mant = 16'd128; cfg_wsel = 2'd3;
        send_cplx(3, -3, "R4 tie");
        chk(out_i == 16'd2 && out_q == 16'hFFFE, "R4 tie values 2/-2", sx(out_i), 2);

        // R5 full-scale saturation
        cfg_mant = 16'hFFFF; cfg_shift = 3'd7; cfg_wsel = 2'd0;
        send_cplx(32767, -32768, "R5 sat");
        chk(sx(out_i) == 511 && sx(out_q) == -512, "R5 10-bit limits", sx(out_q), -512);

        // R3 and R6 sweep in complex format
        for (int w = 0; w < 4; w++)
            for (int s = 0; s < 4; s++)
                for (int m = 0; m < 5; m++)
                    for (int v = 0; v < 8; v++) begin
                        cfg_wsel = 2'(w); cfg_shift = 3'(shs[s]); cfg_mant = 16'(mants[m]);
                        send_cplx(vals[v], vals[7 - v], "R3 R6 sweep");
                    end

        // R6 unity width scaling: 1000 at 10 bits is 1000/64 = 15.6 -> 16
        cfg_mant = 16'd256; cfg_shift = 3'd0; cfg_wsel = 2'd0;
        send_cplx(1000, -1000, "R6 width");
        chk(sx(out_i) == 16 && sx(out_q) == -16, "R6 10-bit 1000 -> 16", sx(out_i), 16);

        // R7 inversion
        cfg_wsel = 2'd3; cfg_inv = 1'b1;
        send_cplx(500, 700, "R7 inv");
        chk(sx(out_i) == 500 && sx(out_q) == -700, "R7 Q negated only", sx(out_q), -700);
        cfg_inv = 1'b0;

        // R8 half-rate offset: parity continues from the samples above
        cfg_half = 1'b1;
        for (int k = 0; k < 4; k++) begin
            logic [15:0] e;
            e = half_ph ? 16'hFC18 : 16'd1000;
            send_cplx(1000, 1000, "R8 offset");
            chk(out_i == e && out_q == e, "R8 alternate sign", sx(out_i), sx(e));
        end
        cfg_half = 1'b0;

        // R9 rotation I, -Q, -I, Q
        cfg_wsel = 2'd3; cfg_mant = 16'd256; cfg_shift = 3'd0;
        send_real(100, 200, "R9 rot0");
        send_real(100, 200, "R9 rot1");
        chk(sx(out_i) == 200 && sx(rb_i) == -100, "R9 odd sample -I then Q", sx(rb_i), -100);

        // Combined signs and saturation on the Q path
        cfg_inv = 1'b1; cfg_half = 1'b1;
        for (int k = 0; k < 4; k++) send_cplx(-32768, -32768, "R7 R8 combined");
        for (int k = 0; k < 4; k++) send_real(-32768, -32768, "R9 combined");
        for (int w = 0; w < 4; w++)
            for (int v = 0; v < 8; v++) begin
                cfg_wsel = 2'(w); cfg_mant = 16'd300; cfg_shift = 3'd2;
                send_real(vals[v], vals[(v + 3) % 8], "R9 sweep");
            end
        cfg_inv = 1'b0; cfg_half = 1'b0;

        // R9 rotation restarts after a complex sample
        cfg_wsel = 2'd3; cfg_mant = 16'd256; cfg_shift = 3'd0;
        send_real(10, 20, "R9 pre");
        send_cplx(10, 20, "R9 break");
        send_real(10, 20, "R9 restart");
        chk(sx(out_i) == -20 && sx(rb_i) == 10, "R9 restart at I", sx(rb_i), 10);

        // R10 readback holds while idle
        repeat (5) @(negedge clk);
        chk(sx(rb_i) == 10 && sx(rb_q) == -20, "R10 hold", sx(rb_q), -20);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule